// File: doc/BRIEF.md
# Received Pause Transmit Inhibitor

This block sits between a MAC receive parser, the transmit engine and a software-owned send request. The receiver hands it one control-frame event per parsed frame: whether the frame carries the pause opcode, and the 16-bit quanta value it carries. When pause handling is enabled, a pause event loads a countdown. The countdown steps down once per quanta tick, and each tick marks 512 bit times on the wire. While the countdown is non-zero, no new frame start is released to the transmitter.

Software raises a send request with a one-cycle pulse. The request stays pending until the transmitter reports the frame done, and the request is the only thing software sees. A pause only makes the pending request wait a little longer, so software never observes it directly. A frame that is already on the wire is never cut short. A pass-all control picks what happens to each received control frame: it is either marked for discard, or forwarded so that the application can read it and track pause state itself.

Top module: `pause_tx_inhibit`

## Requirements
- R1: While reset is asserted and for the cycles until its synchronous release completes, tx_req_pending, tx_start, ctl_drop, ctl_fwd and paused are all 0.
- R2: With rx_pause_en = 1, a ctl_valid pulse with ctl_is_pause = 1 and a non-zero ctl_quanta loads the countdown with that value, and paused reads 1 in the following cycle.
- R3: Each quanta_tick pulse lowers a non-zero countdown by exactly one, and a zero countdown stays at zero. paused is 1 exactly while the countdown is non-zero.
- R4: A pause event that arrives while a countdown is running reloads the countdown with the new value. When a pause event and a quanta_tick fall in the same cycle, the load wins and the tick is lost.
- R5: A pause event carrying a quanta value of 0 does not start a pause, and it ends any pause already in progress: paused is 0 in the following cycle.
- R6: With rx_pause_en = 0, pause events are ignored, and any running countdown is cleared in the next cycle.
- R7: A tx_req_set pulse makes tx_req_pending read 1 in the next cycle. The flag stays 1 until its frame completes.
- R8: tx_start is a single-cycle pulse. It is raised in the cycle after one in which the request is pending, no frame is in progress and paused is 0. No tx_start is issued while paused is 1.
- R9: Once tx_start has been issued, the frame is in progress. A pause arriving during the frame has no effect on it. A tx_done pulse ends the frame and clears tx_req_pending in the next cycle. tx_done outside a frame has no effect.
- R10: Every ctl_valid pulse produces, one cycle later, a one-cycle pulse on ctl_drop when pass_all = 0, or on ctl_fwd when pass_all = 1, never both. A control frame with ctl_is_pause = 0 never changes the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pause_en | input | 1 | Enables reaction to received pause frames |
| pass_all | input | 1 | 1: forward control frames to the application; 0: mark them for discard |
| ctl_valid | input | 1 | One-cycle pulse: a valid control frame has been parsed |
| ctl_is_pause | input | 1 | The parsed control frame carries the pause opcode |
| ctl_quanta | input | 16 | Pause quanta value carried by the frame |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| tx_req_set | input | 1 | Software pulse that raises the send request |
| tx_done | input | 1 | Transmitter pulse: the current frame has gone out |
| tx_req_pending | output | 1 | Software-visible send request flag |
| tx_start | output | 1 | One-cycle pulse that starts a frame in the transmitter |
| ctl_drop | output | 1 | Marks the just-received control frame for discard |
| ctl_fwd | output | 1 | Marks the just-received control frame for delivery to the application |
| paused | output | 1 | Debug status: countdown non-zero |

## Verification
The first stimulus is a sequence of directed patterns. Each one tells apart a pair of behaviours that are easy to confuse: reload against decrement, zero-quanta cancel against a zero countdown that is simply left alone, a disabled enable against an ignored frame, and a pause that arrives before a frame start against one that arrives during a frame. After these, constrained-random traffic mixes pause events with small quanta values, frequent ticks, request pulses, done pulses and pass-all toggles. A cycle model built from the requirements checks every output in every cycle. This mixing brings out same-cycle collisions such as load with tick, request with done, and pause with start.

// File: rtl/pi_pkg.sv
package pi_pkg;
  localparam int unsigned PI_QUANTA_W = 16;

  typedef enum logic [0:0] {
    GATE_IDLE = 1'b0,
    GATE_BUSY = 1'b1
  } gate_state_e;
endpackage

// File: rtl/pi_rst_sync.sv
module pi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[LAST-1:0], 1'b1};
  end

  assign rst_sync_n = sync_q[LAST];
endmodule

// File: rtl/pi_pause_timer.sv
module pi_pause_timer #(
  parameter int unsigned QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [QW-1:0] quanta_i,
  input  logic          tick_i,
  output logic          paused_o
);
  localparam logic [QW-1:0] ZERO = '0;
  localparam logic [QW-1:0] ONE  = {{(QW-1){1'b0}}, 1'b1};

  logic [QW-1:0] cnt_q, cnt_d;
  logic          cnt_we;
  logic          running;

  assign running = (cnt_q != ZERO);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_we = 1'b0;
    if (!en_i) begin
      cnt_d  = ZERO;
      cnt_we = running;
    end else if (load_i) begin
      cnt_d  = quanta_i;
      cnt_we = 1'b1;
    end else if (tick_i && running) begin
      cnt_d  = cnt_q - ONE;
      cnt_we = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign paused_o = running;

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && load_i) |=> (cnt_q == $past(quanta_i))); // R2
  AST_TICK_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !load_i && tick_i && running) |=> (cnt_q == $past(cnt_q) - ONE)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !load_i && !tick_i) |=> $stable(cnt_q)); // R3
  AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !paused_o); // R6
endmodule

// File: rtl/pi_ctl_filter.sv
module pi_ctl_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_all_i,
  input  logic ctl_valid_i,
  input  logic ctl_is_pause_i,
  output logic pause_load_o,
  output logic drop_o,
  output logic fwd_o
);
  logic drop_q, drop_d;
  logic fwd_q,  fwd_d;

  always_comb begin
    drop_d = ctl_valid_i && !pass_all_i;
    fwd_d  = ctl_valid_i &&  pass_all_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0;
      fwd_q  <= 1'b0;
    end else begin
      drop_q <= drop_d;
      fwd_q  <= fwd_d;
    end
  end

  assign pause_load_o = ctl_valid_i && ctl_is_pause_i;
  assign drop_o       = drop_q;
  assign fwd_o        = fwd_q;

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(drop_o && fwd_o)); // R10
  AST_VERDICT_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid_i |=> (drop_o || fwd_o)); // R10
  AST_NO_SPURIOUS_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_valid_i |=> !(drop_o || fwd_o)); // R10
endmodule

// File: rtl/pi_tx_gate.sv
module pi_tx_gate
  import pi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_set_i,
  input  logic done_i,
  input  logic paused_i,
  output logic pending_o,
  output logic start_o
);
  gate_state_e state_q, state_d;
  logic        flag_q, flag_d;
  logic        start_q, start_d;

  always_comb begin
    state_d = state_q;
    flag_d  = flag_q;
    start_d = 1'b0;
    unique case (state_q)
      GATE_IDLE: begin
        if (req_set_i) flag_d = 1'b1;
        if (flag_q && !paused_i) begin
          state_d = GATE_BUSY;
          start_d = 1'b1;
        end
      end
      GATE_BUSY: begin
        if (done_i) begin
          state_d = GATE_IDLE;
          flag_d  = 1'b0;
        end
      end
      default: state_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
      flag_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
      start_q <= start_d;
    end
  end

  assign pending_o = flag_q;
  assign start_o   = start_q;

  AST_START_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R8
  AST_NO_START_WHILE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(!paused_i)); // R8
  AST_BUSY_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GATE_BUSY) |-> pending_o); // R9
  AST_SET_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_set_i && state_q == GATE_IDLE) |=> pending_o); // R7
endmodule

// File: rtl/pause_tx_inhibit.sv
module pause_tx_inhibit
  import pi_pkg::*;
#(
  parameter int unsigned QW         = PI_QUANTA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_pause_en,
  input  logic          pass_all,
  input  logic          ctl_valid,
  input  logic          ctl_is_pause,
  input  logic [QW-1:0] ctl_quanta,
  input  logic          quanta_tick,
  input  logic          tx_req_set,
  input  logic          tx_done,
  output logic          tx_req_pending,
  output logic          tx_start,
  output logic          ctl_drop,
  output logic          ctl_fwd,
  output logic          paused
);
  logic rst_core_n;
  logic pause_load;
  logic paused_int;

  pi_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pi_ctl_filter u_filt (
    .clk            (clk),
    .rst_n          (rst_core_n),
    .pass_all_i     (pass_all),
    .ctl_valid_i    (ctl_valid),
    .ctl_is_pause_i (ctl_is_pause),
    .pause_load_o   (pause_load),
    .drop_o         (ctl_drop),
    .fwd_o          (ctl_fwd)
  );

  pi_pause_timer #(.QW(QW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en_i     (rx_pause_en),
    .load_i   (pause_load),
    .quanta_i (ctl_quanta),
    .tick_i   (quanta_tick),
    .paused_o (paused_int)
  );

  pi_tx_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_set_i (tx_req_set),
    .done_i    (tx_done),
    .paused_i  (paused_int),
    .pending_o (tx_req_pending),
    .start_o   (tx_start)
  );

  assign paused = paused_int;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_core_n |-> !(tx_start || tx_req_pending || paused || ctl_drop || ctl_fwd)); // R1
  AST_ZERO_QUANTA_CANCELS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rx_pause_en && ctl_valid && ctl_is_pause && ctl_quanta == '0) |=> !paused); // R5
  AST_NONPAUSE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctl_valid && !ctl_is_pause && !paused && rx_pause_en) |=> !paused); // R10
endmodule

// File: tb/sim_pause_tx_inhibit.sv
module sim_pause_tx_inhibit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  QW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_pause_en, pass_all, ctl_valid, ctl_is_pause, quanta_tick, tx_req_set, tx_done;
  logic [QW-1:0] ctl_quanta;
  logic tx_req_pending, tx_start, ctl_drop, ctl_fwd, paused;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  logic [QW-1:0] m_cnt;
  logic m_flag, m_busy, m_start, m_drop, m_fwd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_tx_inhibit #(.QW(QW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_pause_en(rx_pause_en), .pass_all(pass_all),
    .ctl_valid(ctl_valid), .ctl_is_pause(ctl_is_pause), .ctl_quanta(ctl_quanta),
    .quanta_tick(quanta_tick), .tx_req_set(tx_req_set), .tx_done(tx_done),
    .tx_req_pending(tx_req_pending), .tx_start(tx_start), .ctl_drop(ctl_drop),
    .ctl_fwd(ctl_fwd), .paused(paused)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [QW-1:0] next_cnt(logic [QW-1:0] c);
    if (!rx_pause_en) return '0;
    if (ctl_valid && ctl_is_pause) return ctl_quanta;
    if (quanta_tick && c != '0) return c - 1'b1;
    return c;
  endfunction

  task automatic clr_pulses();
    ctl_valid = 0; ctl_is_pause = 0; ctl_quanta = '0;
    quanta_tick = 0; tx_req_set = 0; tx_done = 0;
  endtask

  // advance one cycle: model from current inputs, then compare at the negedge
  task automatic step();
    logic [QW-1:0] c_n;
    logic f_n, b_n, s_n;
    c_n = next_cnt(m_cnt);
    f_n = m_flag; b_n = m_busy; s_n = 1'b0;
    if (!m_busy) begin
      if (tx_req_set) f_n = 1'b1;
      if (m_flag && m_cnt == '0) begin b_n = 1'b1; s_n = 1'b1; end
    end else if (tx_done) begin
      b_n = 1'b0; f_n = 1'b0;
    end
    m_drop = ctl_valid && !pass_all;
    m_fwd  = ctl_valid && pass_all;
    m_cnt = c_n; m_flag = f_n; m_busy = b_n; m_start = s_n;
    @(negedge clk);
    chk("R3 paused", paused, (m_cnt != '0));
    chk("R8 tx_start", tx_start, m_start);
    chk("R7 tx_req_pending", tx_req_pending, m_flag);
    chk("R10 ctl_drop", ctl_drop, m_drop);
    chk("R10 ctl_fwd", ctl_fwd, m_fwd);
    clr_pulses();
  endtask

  task automatic pause_frame(logic [QW-1:0] q, bit tick);
    ctl_valid = 1; ctl_is_pause = 1; ctl_quanta = q; quanta_tick = tick;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; rx_pause_en = 0; pass_all = 0; clr_pulses();
    m_cnt = '0; m_flag = 0; m_busy = 0; m_start = 0; m_drop = 0; m_fwd = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {tx_req_pending, tx_start, ctl_drop, ctl_fwd, paused}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 after sync release", {tx_req_pending, tx_start, ctl_drop, ctl_fwd, paused}, 0);

    // R7/R8/R9: plain send
    tx_req_set = 1; step();
    chk("R7 flag set", tx_req_pending, 1);
    step();
    chk("R8 start issued", tx_start, 1);
    step(); step();
    tx_done = 1; step();
    chk("R9 flag cleared by done", tx_req_pending, 0);

    // R2/R3/R8: pause holds a request
    rx_pause_en = 1;
    pause_frame(16'd3, 0);
    chk("R2 pause loaded", paused, 1);
    tx_req_set = 1; step();
    repeat (3) step();
    chk("R8 held while paused", tx_start, 0);
    quanta_tick = 1; step();
    quanta_tick = 1; step();
    chk("R3 still paused after two ticks", paused, 1);
    quanta_tick = 1; step();
    chk("R3 pause ended", paused, 0);
    step();
    chk("R8 start after pause", tx_start, 1);
    // R9: pause during frame does not abort it
    pause_frame(16'd2, 0);
    chk("R9 flag kept during frame", tx_req_pending, 1);
    tx_done = 1; step();
    chk("R9 done clears flag", tx_req_pending, 0);

    // R4: reload mid-count, load beats tick
    pause_frame(16'd3, 0);
    quanta_tick = 1; step();
    pause_frame(16'd2, 1);
    quanta_tick = 1; step();
    chk("R4 reload kept pause", paused, 1);
    quanta_tick = 1; step();
    chk("R4 reload count expired", paused, 0);

    // R5: zero quanta cancels
    pause_frame(16'd9, 0);
    pause_frame(16'd0, 0);
    chk("R5 zero quanta ends pause", paused, 0);
    pause_frame(16'd0, 0);
    chk("R5 zero quanta no pause", paused, 0);

    // R6: disable
    pause_frame(16'd9, 0);
    rx_pause_en = 0; step();
    chk("R6 disable clears", paused, 0);
    pause_frame(16'd9, 0);
    chk("R6 ignored while disabled", paused, 0);
    rx_pause_en = 1;

    // R10: pass-all and non-pause frames
    pass_all = 0; ctl_valid = 1; ctl_quanta = 16'd7; step();
    chk("R10 drop when pass_all clear", ctl_drop, 1);
    chk("R10 non-pause no load", paused, 0);
    pass_all = 1; ctl_valid = 1; step();
    chk("R10 fwd when pass_all set", ctl_fwd, 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      rx_pause_en  = ($urandom_range(0, 19) != 0);
      if ($urandom_range(0, 9) == 0) pass_all = $urandom_range(0, 1);
      ctl_valid    = ($urandom_range(0, 7) == 0);
      ctl_is_pause = ($urandom_range(0, 3) != 0);
      ctl_quanta   = QW'($urandom_range(0, 6));
      quanta_tick  = ($urandom_range(0, 2) == 0);
      tx_req_set   = ($urandom_range(0, 5) == 0);
      tx_done      = ($urandom_range(0, 3) == 0);
      step();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule